// File: doc/BRIEF.md
# Debug Memory Access Port with Address Auto-Increment

This block sits behind a debug port as a slave on the internal debug bus and reaches system memory as a master on a simple request/acknowledge bus. The debug side sees 64 slots of 32 bits. A slot is picked by a 4-bit bank number and a 2-bit register index, so the slot number is `{bank, index}`. Four slots are implemented: a control word, a transfer-address word, a data window and a read-only identity word. Every other slot reads as zero and ignores writes.

Each access to the data window starts exactly one memory transaction at the address held in the transfer-address word. When the control word enables stepping, the address moves on by 4 after each access that completes without error. A block of n consecutive words can therefore be written with one address write followed by n data writes. While a memory transaction is outstanding the port is busy and holds off new debug requests, so the debug port answers WAIT. A memory error comes back as a faulted response. An abort strobe from the debug port ends a transaction that has hung and releases the port.

The debug request channel is valid/ready. The debug port raises `dbg_req_valid` and keeps all request fields stable until it samples `dbg_req_ready` high at a rising edge. The port never accepts a request while it is busy. Each accepted request gets exactly one response pulse. The response has no back-pressure.

Top module: `memap_port`

## Requirements
- R1: After reset, `dbg_req_ready` is 1 and `busy`, `mem_req` and `dbg_rsp_valid` are 0. The control word and the transfer-address word are 0.
- R2: Slot bank 15, index 3 returns the parameter `ID_VALUE`, default 32'h1A70_0E21. Writes to it are ignored.
- R3: Slot bank 0, index 0 is the control word. Bit 0 enables stepping and reads back as written, with all other bits reading 0. Slot bank 0, index 1 is the transfer-address word, which is read/write over all 32 bits.
- R4: Every slot other than bank 0 index 0, 1 or 3 and bank 15 index 3 reads 0 and ignores writes.
- R5: An access to slot bank 0, index 3 issues exactly one memory transaction. During it, `mem_addr` equals the transfer-address word, `mem_write` equals the request direction and `mem_wdata` equals the request data. `mem_req` and these fields hold steady until `mem_ack` or abort.
- R6: A data-window read responds one cycle after the acknowledging edge with the `mem_rdata` value present at that edge and fault 0.
- R7: With stepping enabled, the transfer-address word grows by 4 (modulo 2^32) after each successful data-window access. With stepping disabled, it is unchanged.
- R8: `busy` is 1 from the cycle after a data-window request is accepted until the cycle after its acknowledge or abort. `dbg_req_ready` is 0 whenever `busy` is 1.
- R9: A memory acknowledge with `mem_err` set gives a response with fault 1 and read data 0. It leaves the transfer-address word unchanged.
- R10: Abort while busy drops `mem_req` and `busy` at the next edge and gives a response with fault 1 and no address step. This holds even when `mem_ack` arrives in the same cycle. Abort while idle has no effect.
- R11: A request to any slot other than the data window responds one cycle after acceptance with fault 0. Write responses carry read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| dbg_req_valid | input | 1 | Debug request present |
| dbg_req_ready | output | 1 | Port can accept a request |
| dbg_req_write | input | 1 | 1 for write, 0 for read |
| dbg_req_bank | input | 4 | Bank number of the slot |
| dbg_req_reg | input | 2 | Register index inside the bank |
| dbg_req_wdata | input | 32 | Write data |
| dbg_rsp_valid | output | 1 | One-cycle response strobe |
| dbg_rsp_fault | output | 1 | Response reports a failed transfer |
| dbg_rsp_rdata | output | 32 | Response read data |
| dbg_abort | input | 1 | Terminate the outstanding memory transaction |
| busy | output | 1 | Memory transaction outstanding |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_write | output | 1 | Memory direction |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Memory error, valid with acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |

## Verification
The bench sweeps every slot after reset and again after writing a distinct pattern to each one. A decoder that aliased banks or let a write land in an empty slot would return a nonzero or stale word there. It runs block writes and block reads of one to five words at memory latencies of zero to three cycles, checking the final address and every stored word. An engine that stepped on the wrong edge, stepped twice or issued an extra transaction would leave a shifted image or a wrong acknowledge count. Separate cases cover the address wrapping from 0xFFFFFFFC to 0, an erroring access that must not move the address, and an abort. The abort case covers both a hung bus and a bus that acknowledges in the same cycle as the abort. A design that gave the acknowledge priority would step the address or report success there.

// File: rtl/memap_pkg.sv
package memap_pkg;
  localparam int REG_W = 2;
  localparam logic [REG_W-1:0] IDX_CTRL = 2'd0;
  localparam logic [REG_W-1:0] IDX_TAR  = 2'd1;
  localparam logic [REG_W-1:0] IDX_DATA = 2'd3;
  localparam logic [REG_W-1:0] IDX_IDENT = 2'd3;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_WAIT = 1'b1
  } eng_state_e;
endpackage

// File: rtl/memap_slot_regs.sv
module memap_slot_regs
  import memap_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int INC_STEP = 4,
  parameter logic [31:0] ID_VALUE = 32'h1A70_0E21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic [REG_W-1:0]  regi,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xfer_end,
  input  logic              step_ok,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] tar,
  output logic              inc_en
);
  localparam logic [BANK_W-1:0] BANK_FIRST = '0;
  localparam logic [BANK_W-1:0] BANK_LAST  = '1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INC_STEP);

  logic sel_ctrl, sel_tar, sel_ident;

  always_comb begin
    sel_ctrl  = (bank == BANK_FIRST) && (regi == IDX_CTRL);
    sel_tar   = (bank == BANK_FIRST) && (regi == IDX_TAR);
    sel_ident = (bank == BANK_LAST)  && (regi == IDX_IDENT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_en <= 1'b0;
    end else if (wr_en && sel_ctrl) begin
      inc_en <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tar <= '0;
    end else if (wr_en && sel_tar) begin
      tar <= wdata[ADDR_W-1:0];
    end else if (step_ok && inc_en) begin
      tar <= tar + STEP;
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel_ctrl)       rd_data = DATA_W'(inc_en);
    else if (sel_tar)   rd_data = DATA_W'(tar);
    else if (sel_ident) rd_data = DATA_W'(ID_VALUE);
  end

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && inc_en && !wr_en) |=> (tar == $past(tar) + STEP));

  assert_hold_nostep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !inc_en && !wr_en) |=> $stable(tar));

  assert_fault_keeps_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !step_ok && !wr_en) |=> $stable(tar));
endmodule

// File: rtl/memap_bus_engine.sv
module memap_bus_engine
  import memap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              abort,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              done_ok,
  output logic              done_fault,
  output logic [DATA_W-1:0] done_rdata
);
  eng_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (start) begin
          state     <= ENG_WAIT;
          mem_write <= start_write;
          mem_addr  <= start_addr;
          mem_wdata <= start_wdata;
        end
        ENG_WAIT: if (abort || mem_ack) state <= ENG_IDLE;
        default: state <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state == ENG_WAIT);
    mem_req    = busy;
    done       = busy && (abort || mem_ack);
    done_fault = abort || mem_err;
    done_ok    = busy && mem_ack && !mem_err && !abort;
    done_rdata = (mem_write || abort || mem_err) ? '0 : mem_rdata;
  end

  assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  assert_req_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !abort) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  assert_abort_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (!busy && !mem_req));
endmodule

// File: rtl/memap_port.sv
module memap_port
  import memap_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int INC_STEP = 4,
  parameter logic [31:0] ID_VALUE = 32'h1A70_0E21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_req_valid,
  output logic              dbg_req_ready,
  input  logic              dbg_req_write,
  input  logic [BANK_W-1:0] dbg_req_bank,
  input  logic [REG_W-1:0]  dbg_req_reg,
  input  logic [DATA_W-1:0] dbg_req_wdata,
  output logic              dbg_rsp_valid,
  output logic              dbg_rsp_fault,
  output logic [DATA_W-1:0] dbg_rsp_rdata,
  input  logic              dbg_abort,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [BANK_W-1:0] BANK_FIRST = '0;

  logic              accept, is_data, reg_acc, start;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] tar;
  logic              inc_en;
  logic              eng_done, eng_ok, eng_fault;
  logic [DATA_W-1:0] eng_rdata;

  always_comb begin
    dbg_req_ready = !busy;
    accept  = dbg_req_valid && dbg_req_ready;
    is_data = (dbg_req_bank == BANK_FIRST) && (dbg_req_reg == IDX_DATA);
    reg_acc = accept && !is_data;
    start   = accept && is_data;
  end

  memap_slot_regs #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .INC_STEP(INC_STEP), .ID_VALUE(ID_VALUE)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .bank(dbg_req_bank), .regi(dbg_req_reg),
    .wr_en(reg_acc && dbg_req_write), .wdata(dbg_req_wdata),
    .xfer_end(eng_done), .step_ok(eng_ok),
    .rd_data(rd_data), .tar(tar), .inc_en(inc_en)
  );

  memap_bus_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_write(dbg_req_write),
    .start_addr(tar), .start_wdata(dbg_req_wdata),
    .abort(dbg_abort), .busy(busy),
    .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .done(eng_done), .done_ok(eng_ok),
    .done_fault(eng_fault), .done_rdata(eng_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_rsp_valid <= 1'b0;
      dbg_rsp_fault <= 1'b0;
      dbg_rsp_rdata <= '0;
    end else begin
      dbg_rsp_valid <= reg_acc || eng_done;
      dbg_rsp_fault <= eng_done && eng_fault;
      if (eng_done)                      dbg_rsp_rdata <= eng_rdata;
      else if (reg_acc && !dbg_req_write) dbg_rsp_rdata <= rd_data;
      else                               dbg_rsp_rdata <= '0;
    end
  end

  assert_reg_rsp_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_acc |=> (dbg_rsp_valid && !dbg_rsp_fault));

  assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !dbg_req_ready));

  assert_err_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_ack && mem_err) |=> (dbg_rsp_valid && dbg_rsp_fault));
endmodule

// File: tb/test_memap_port.sv
module test_memap_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h1A70_0E21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_req_valid = 1'b0, dbg_req_write = 1'b0;
  logic [3:0] dbg_req_bank = '0;
  logic [1:0] dbg_req_reg = '0;
  logic [31:0] dbg_req_wdata = '0;
  logic dbg_req_ready, dbg_rsp_valid, dbg_rsp_fault;
  logic [31:0] dbg_rsp_rdata;
  logic dbg_abort = 1'b0;
  logic busy, mem_req, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  int total = 0, bad = 0;
  int lat = 0, wait_cnt = 0, acks = 0;
  bit hang = 0, poke_ack = 0, err_en = 0;
  logic [31:0] err_addr = '0;
  logic [31:0] mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  memap_port i_memap_port (
    .clk(clk), .rst_n(rst_n),
    .dbg_req_valid(dbg_req_valid), .dbg_req_ready(dbg_req_ready),
    .dbg_req_write(dbg_req_write), .dbg_req_bank(dbg_req_bank),
    .dbg_req_reg(dbg_req_reg), .dbg_req_wdata(dbg_req_wdata),
    .dbg_rsp_valid(dbg_rsp_valid), .dbg_rsp_fault(dbg_rsp_fault),
    .dbg_rsp_rdata(dbg_rsp_rdata), .dbg_abort(dbg_abort), .busy(busy),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata)
  );

  // memory model: acknowledges after lat waiting cycles
  always @(negedge clk) begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    if (poke_ack) mem_ack = 1'b1;
    else if (mem_req && !hang) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0; mem_ack = 1'b1; acks++;
        if (err_en && mem_addr == err_addr) mem_err = 1'b1;
        else if (mem_write) mem[mem_addr[5:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[5:2]];
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input string tag, input logic wr, input logic [3:0] bk,
                      input logic [1:0] rg, input logic [31:0] wd,
                      output logic [31:0] rd, output logic flt);
    int guard;
    bit is_data;
    is_data = (bk == 4'd0) && (rg == 2'd3);
    @(negedge clk);
    dbg_req_valid = 1'b1; dbg_req_write = wr; dbg_req_bank = bk;
    dbg_req_reg = rg; dbg_req_wdata = wd;
    guard = 0;
    while (!dbg_req_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    dbg_req_valid = 1'b0;
    if (is_data) begin
      chk({tag, " R8 busy"}, 32'(busy), 32'd1);
      chk({tag, " R8 ready"}, 32'(dbg_req_ready), 32'd0);
    end
    guard = 0;
    while (!dbg_rsp_valid && guard < 1000) begin @(negedge clk); guard++; end
    if (!is_data) begin
      chk({tag, " R11 latency"}, 32'(guard), 32'd0);
      chk({tag, " R11 fault"}, 32'(dbg_rsp_fault), 32'd0);
      if (wr) chk({tag, " R11 wdata rsp"}, dbg_rsp_rdata, 32'd0);
    end
    rd = dbg_rsp_rdata; flt = dbg_rsp_fault;
  endtask

  function automatic logic [31:0] pat(input int s);
    return 32'h1234_5601 ^ 32'(s);
  endfunction

  task automatic set_reg(input logic [1:0] rg, input logic [31:0] v);
    logic [31:0] rd; logic f;
    xfer("setup", 1'b1, 4'd0, rg, v, rd, f);
  endtask

  task automatic get_tar(output logic [31:0] v);
    logic f;
    xfer("tar", 1'b0, 4'd0, 2'd1, 32'd0, v, f);
  endtask

  task automatic launch_hung(input logic [31:0] wd);
    @(negedge clk);
    dbg_req_valid = 1'b1; dbg_req_write = 1'b1; dbg_req_bank = 4'd0;
    dbg_req_reg = 2'd3; dbg_req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    dbg_req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, t, exp;
    logic f;
    int a0;
    for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(dbg_req_ready), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 rsp_valid", 32'(dbg_rsp_valid), 32'd0);

    // R1 R2 R4 R6: read every slot after reset
    for (int s = 0; s < 64; s++) begin
      xfer("sweep0", 1'b0, 4'(s >> 2), 2'(s), 32'd0, rd, f);
      if (s == 63) exp = ID;
      else if (s == 3) exp = 32'hC0DE_0000;
      else exp = 32'd0;
      chk($sformatf("R4 R2 R6 slot %0d after reset", s), rd, exp);
    end

    // R2 R3 R4: write pattern to every slot except the data window
    for (int s = 0; s < 64; s++)
      if (s != 3) xfer("wsweep", 1'b1, 4'(s >> 2), 2'(s), pat(s), rd, f);
    for (int s = 0; s < 64; s++) begin
      if (s == 3) continue;
      xfer("rsweep", 1'b0, 4'(s >> 2), 2'(s), 32'd0, rd, f);
      if (s == 0) exp = pat(0) & 32'd1;
      else if (s == 1) exp = pat(1);
      else if (s == 63) exp = ID;
      else exp = 32'd0;
      chk($sformatf("R3 R4 R2 slot %0d readback", s), rd, exp);
    end

    // R5 R6 R7: block writes and reads across latency and length
    for (int l = 0; l < 4; l++) begin
      for (int n = 1; n <= 5; n++) begin
        lat = l;
        set_reg(2'd0, 32'd1);
        set_reg(2'd1, 32'd0);
        a0 = acks;
        for (int i = 0; i < n; i++)
          xfer("blkw", 1'b1, 4'd0, 2'd3, 32'hB000_0000 | 32'(l << 8) | 32'(n << 4) | 32'(i), rd, f);
        chk("R5 one transaction per write", 32'(acks - a0), 32'(n));
        get_tar(t);
        chk("R7 address after block", t, 32'(4 * n));
        for (int i = 0; i < n; i++)
          chk("R5 stored word", mem[i], 32'hB000_0000 | 32'(l << 8) | 32'(n << 4) | 32'(i));
        set_reg(2'd1, 32'd0);
        for (int i = 0; i < n; i++) begin
          xfer("blkr", 1'b0, 4'd0, 2'd3, 32'd0, rd, f);
          chk("R6 read data", rd, 32'hB000_0000 | 32'(l << 8) | 32'(n << 4) | 32'(i));
          chk("R6 read fault", 32'(f), 32'd0);
        end
      end
    end
    lat = 1;

    // R7 stepping disabled
    set_reg(2'd0, 32'd0);
    set_reg(2'd1, 32'h20);
    xfer("noinc", 1'b1, 4'd0, 2'd3, 32'h5555_AAAA, rd, f);
    get_tar(t);
    chk("R7 no step when disabled", t, 32'h20);
    chk("R5 write at held address", mem[8], 32'h5555_AAAA);

    // R7 wrap
    set_reg(2'd0, 32'd1);
    set_reg(2'd1, 32'hFFFF_FFFC);
    xfer("wrap", 1'b1, 4'd0, 2'd3, 32'h0BAD_F00D, rd, f);
    get_tar(t);
    chk("R7 wrap to zero", t, 32'd0);

    // R9 memory error
    err_en = 1; err_addr = 32'h30;
    set_reg(2'd1, 32'h30);
    xfer("err", 1'b0, 4'd0, 2'd3, 32'd0, rd, f);
    chk("R9 fault", 32'(f), 32'd1);
    chk("R9 rdata zero", rd, 32'd0);
    get_tar(t);
    chk("R9 address kept", t, 32'h30);
    err_en = 0;

    // R10 abort of a hung transaction
    hang = 1;
    set_reg(2'd1, 32'h10);
    launch_hung(32'h7777_0001);
    chk("R8 busy while hung", 32'(busy), 32'd1);
    chk("R8 ready low while hung", 32'(dbg_req_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R5 request held", 32'(mem_req), 32'd1);
    chk("R5 address held", mem_addr, 32'h10);
    chk("R5 wdata held", mem_wdata, 32'h7777_0001);
    dbg_abort = 1'b1;
    @(negedge clk);
    dbg_abort = 1'b0;
    chk("R10 mem_req dropped", 32'(mem_req), 32'd0);
    chk("R10 busy cleared", 32'(busy), 32'd0);
    chk("R10 response", 32'(dbg_rsp_valid), 32'd1);
    chk("R10 fault", 32'(dbg_rsp_fault), 32'd1);
    get_tar(t);
    chk("R10 no step on abort", t, 32'h10);

    // R10 abort and acknowledge in the same cycle
    launch_hung(32'h7777_0002);
    @(posedge clk); poke_ack = 1;
    @(negedge clk); dbg_abort = 1'b1;
    @(posedge clk); poke_ack = 0;
    @(negedge clk); dbg_abort = 1'b0;
    chk("R10 same-cycle response", 32'(dbg_rsp_valid), 32'd1);
    chk("R10 same-cycle fault", 32'(dbg_rsp_fault), 32'd1);
    chk("R10 same-cycle busy", 32'(busy), 32'd0);
    get_tar(t);
    chk("R10 same-cycle no step", t, 32'h10);
    hang = 0;

    // R10 abort while idle
    @(negedge clk); dbg_abort = 1'b1;
    @(negedge clk); dbg_abort = 1'b0;
    chk("R10 idle abort no response", 32'(dbg_rsp_valid), 32'd0);
    chk("R10 idle abort busy", 32'(busy), 32'd0);
    get_tar(t);
    chk("R10 idle abort address", t, 32'h10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule